// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Software reaches it through a plain single-cycle 32-bit read/write port with a word index. Each pin has a direction bit. An output pin is driven from a stored value bit. Reading the value register returns what each pin currently shows.

Every pin also feeds its own trigger detector. The detector works on the synchronized pin level and raises an event on one of five triggers: active-high level, active-low level, rising edge, falling edge, or either edge. Three configuration words select the trigger: an edge-or-level word, a polarity word and an either-edge word. Events are latched into a status word. Software clears status bits by writing ones to a clear word. The status word, masked by an enable word, forms the pending word, and the OR of the pending bits drives a single interrupt line. A version word reads 3, which tells software that the either-edge word is present.

Each pin's trigger is decoded into one of five named modes: LVL_LO, LVL_HI, EDGE_FALL, EDGE_RISE, EDGE_ANY. The mode is picked from the three configuration bits, and it decides which comparison of the current and previous synchronized levels counts as an event.

Top module: `gpio_trig_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `pin_out` is 0, the enable word reads 0, the direction word reads all ones over the implemented pins, and `irq` is low.
- R2: A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1), and `pin_out` always carries the stored value word.
- R3: Reading the value word returns the pin level seen through a two-flop synchronizer for input pins, and the stored value bit for output pins.
- R4: With edge-or-level bit 0, the pin is level triggered: polarity 1 means active high, polarity 0 means active low. A clear written while the level is still active leaves the status bit 0 for one cycle, and the bit sets again on the next cycle.
- R5: With edge-or-level bit 1 and either-edge bit 0, polarity 1 latches an event on a rising transition and polarity 0 on a falling one. The opposite transition latches nothing.
- R6: With edge-or-level bit 1 and either-edge bit 1, both transitions latch an event. With edge-or-level bit 0, the either-edge bit has no effect.
- R7: Writing the clear word clears every status bit written as 1 and leaves bits written as 0 unchanged. An edge event in the same cycle as the clear is kept. Without a clear, status bits never fall.
- R8: The status word shows all latched events unmasked. The pending word equals status AND enable. `irq` is the OR of the pending bits. Writes to the status and pending words are ignored.
- R9: The enable word changes only when it is written, even when several pins trigger in the same cycle.
- R10: The version word reads 3, and the clear word reads 0.
- R11: Bits at and above NPINS read as zero in every word, and writes to them are ignored.
- R12: Word indices are: 0 value, 1 direction, 2 enable, 3 status, 4 pending, 5 clear, 6 edge-or-level, 7 polarity, 8 version, 9 either-edge. Byte offsets are four times the index. Other indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| pin_in | input | NPINS | Levels seen at the pins |
| pin_out | output | NPINS | Levels driven on output pins |
| pin_oe | output | NPINS | Output enable per pin (1 = driving) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets a level pin cleared while its level is still active. A design that let the level win would never show the one-cycle zero, and a design that dropped the level would never set the bit again. It also lines up an edge with a clear in the same cycle: a design that gave the clear priority would lose that event. Opposite-direction edges and an either-edge bit on a level-configured pin are driven to catch a trigger decoder that fires too broadly. Several pins trigger at once to show that the enable word is not disturbed. Random trigger words, enables and pin patterns are compared against a bench model of latched status, pending and `irq`.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;

    localparam int unsigned BUS_W     = 32;
    localparam int unsigned IDX_W     = 4;
    localparam logic [BUS_W-1:0] VERSION_ID = 32'd3;

    typedef enum logic [IDX_W-1:0] {
        REG_VALUE = 4'd0,
        REG_DIR   = 4'd1,
        REG_IEN   = 4'd2,
        REG_STAT  = 4'd3,
        REG_PEND  = 4'd4,
        REG_CLR   = 4'd5,
        REG_EDGE  = 4'd6,
        REG_POL   = 4'd7,
        REG_VER   = 4'd8,
        REG_BOTH  = 4'd9
    } reg_idx_e;

    typedef enum logic [2:0] {
        TRIG_LVL_LO    = 3'd0,
        TRIG_LVL_HI    = 3'd1,
        TRIG_EDGE_FALL = 3'd2,
        TRIG_EDGE_RISE = 3'd3,
        TRIG_EDGE_ANY  = 3'd4
    } trig_mode_e;

    // The either-edge bit only matters once edge mode is selected.
    function automatic trig_mode_e decode_trig(logic edge_sel, logic pol, logic both);
        trig_mode_e m;
        if (!edge_sel) begin
            m = pol ? TRIG_LVL_HI : TRIG_LVL_LO;
        end else if (both) begin
            m = TRIG_EDGE_ANY;
        end else begin
            m = pol ? TRIG_EDGE_RISE : TRIG_EDGE_FALL;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_pin_trig.sv
module gpio_pin_trig
    import gpio_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic edge_sel,
    input  logic pol,
    input  logic both,
    output logic lvl_evt,
    output logic edg_evt
);

    logic       prev_q;
    trig_mode_e mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
        end
    end

    assign mode = decode_trig(edge_sel, pol, both);

    always_comb begin
        lvl_evt = 1'b0;
        edg_evt = 1'b0;
        unique case (mode)
            TRIG_LVL_LO:    lvl_evt = ~pin_s;
            TRIG_LVL_HI:    lvl_evt = pin_s;
            TRIG_EDGE_FALL: edg_evt = prev_q & ~pin_s;
            TRIG_EDGE_RISE: edg_evt = ~prev_q & pin_s;
            TRIG_EDGE_ANY:  edg_evt = prev_q ^ pin_s;
            default: begin
                lvl_evt = 1'b0;
                edg_evt = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/gpio_trig_ctrl.sv
module gpio_trig_ctrl
    import gpio_trig_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [IDX_W-1:0]    bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NPINS-1:0]    pin_in,
    output logic [NPINS-1:0]    pin_out,
    output logic [NPINS-1:0]    pin_oe,
    output logic                irq
);

    localparam int unsigned W = NPINS;

    if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_npins
        $error("NPINS must lie between 1 and 32");
    end

    logic [W-1:0] val_q, dir_q, ien_q, stat_q, edge_q, pol_q, both_q;
    logic [W-1:0] pin_s, lvl_evt, edg_evt, clr_mask, stat_d, pend;
    logic [W-1:0] wdata_n;
    logic         wr_en;
    reg_idx_e     idx;

    assign idx     = reg_idx_e'(bus_addr);
    assign wr_en   = bus_sel & bus_wr;
    assign wdata_n = bus_wdata[W-1:0];

    gpio_sync #(.WIDTH(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_pin_trig u_trig (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_s    (pin_s[i]),
            .edge_sel (edge_q[i]),
            .pol      (pol_q[i]),
            .both     (both_q[i]),
            .lvl_evt  (lvl_evt[i]),
            .edg_evt  (edg_evt[i])
        );
    end

    // Configuration and control words.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q  <= '0;
            dir_q  <= '1;
            ien_q  <= '0;
            edge_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (wr_en) begin
            case (idx)
                REG_VALUE: val_q  <= wdata_n;
                REG_DIR:   dir_q  <= wdata_n;
                REG_IEN:   ien_q  <= wdata_n;
                REG_EDGE:  edge_q <= wdata_n;
                REG_POL:   pol_q  <= wdata_n;
                REG_BOTH:  both_q <= wdata_n;
                default:   ;
            endcase
        end
    end

    // Status: a clear beats a level event in the same cycle, an edge event survives it.
    assign clr_mask = (wr_en && idx == REG_CLR) ? wdata_n : '0;
    assign stat_d   = (stat_q & ~clr_mask) | edg_evt | (lvl_evt & ~clr_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign pend    = stat_q & ien_q;
    assign irq     = |pend;
    assign pin_out = val_q;
    assign pin_oe  = ~dir_q;

    always_comb begin
        bus_rdata = '0;
        case (idx)
            REG_VALUE: bus_rdata[W-1:0] = (pin_s & dir_q) | (val_q & ~dir_q);
            REG_DIR:   bus_rdata[W-1:0] = dir_q;
            REG_IEN:   bus_rdata[W-1:0] = ien_q;
            REG_STAT:  bus_rdata[W-1:0] = stat_q;
            REG_PEND:  bus_rdata[W-1:0] = pend;
            REG_EDGE:  bus_rdata[W-1:0] = edge_q;
            REG_POL:   bus_rdata[W-1:0] = pol_q;
            REG_BOTH:  bus_rdata[W-1:0] = both_q;
            REG_VER:   bus_rdata        = VERSION_ID;
            default:   bus_rdata        = '0;
        endcase
    end

endmodule

// File: rtl/gpio_trig_chk.sv
module gpio_trig_chk
    import gpio_trig_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [IDX_W-1:0] bus_addr,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             irq,
    input logic [NPINS-1:0] ien_q,
    input logic [NPINS-1:0] stat_q,
    input logic [NPINS-1:0] edg_evt
);

    localparam int unsigned W = NPINS;

    logic clr_wr, ien_wr;
    assign clr_wr = bus_sel && bus_wr && bus_addr == REG_CLR;
    assign ien_wr = bus_sel && bus_wr && bus_addr == REG_IEN;

    // R9
    ien_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_wr |=> $stable(ien_q));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    // R7
    clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((stat_q & $past(bus_wdata[W-1:0]) & ~$past(edg_evt)) == '0));

    // R7
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (($past(stat_q) & ~stat_q) == '0));

    // R10
    ver_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_VER) |-> (bus_rdata == 32'd3));

    // R10
    clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CLR) |-> (bus_rdata == '0));

endmodule

bind gpio_trig_ctrl gpio_trig_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ien_q     (ien_q),
    .stat_q    (stat_q),
    .edg_evt   (edg_evt)
);

// File: tb/gpio_trig_ctrl_bench.sv
module gpio_trig_ctrl_bench;

    localparam int unsigned NP = 24;
    localparam logic [NP-1:0] ALL = '1;
    localparam logic [3:0] A_VAL = 4'd0, A_DIR = 4'd1, A_IEN = 4'd2, A_STAT = 4'd3,
                           A_PEND = 4'd4, A_CLR = 4'd5, A_EDGE = 4'd6, A_POL = 4'd7,
                           A_VER = 4'd8, A_BOTH = 4'd9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_trig_ctrl #(.NPINS(NP)) u_gpio_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a negedge; returns just after the next negedge.
    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [NP-1:0] trig_expect(logic [NP-1:0] o, logic [NP-1:0] n,
                                                 logic [NP-1:0] e, logic [NP-1:0] p,
                                                 logic [NP-1:0] b);
        logic [NP-1:0] r = '0;
        for (int i = 0; i < NP; i++) begin
            if (!e[i])      r[i] = p[i] ? (o[i] | n[i]) : (~o[i] | ~n[i]);
            else if (b[i])  r[i] = o[i] ^ n[i];
            else if (p[i])  r[i] = ~o[i] & n[i];
            else            r[i] = o[i] & ~n[i];
        end
        return r;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, rd2;
        logic [NP-1:0] old_p, new_p, e, p, b, en, exp_s;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", {8'h0, pin_oe}, 32'h0);
        check("R1 pin_out", {8'h0, pin_out}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        bus_read(A_IEN, rd); check("R1 enable", rd, 32'h0);
        bus_read(A_DIR, rd); check("R1 direction", rd, 32'h00FF_FFFF);

        // R10 / R12 fixed words
        bus_read(A_VER, rd); check("R10 version", rd, 32'd3);
        bus_read(A_CLR, rd); check("R10 clear reads", rd, 32'h0);
        bus_read(4'd12, rd); check("R12 unmapped index", rd, 32'h0);

        // R2 / R3 direction and value
        bus_write(A_DIR, 32'h0000_FF00);
        bus_write(A_VAL, 32'h00A5_C3A5);
        pin_in = 24'h12_3456;
        settle();
        #1 check("R2 pin_oe", {8'h0, pin_oe}, 32'h00FF_00FF);
        check("R2 pin_out", {8'h0, pin_out}, 32'h00A5_C3A5);
        bus_read(A_VAL, rd);
        check("R3 value read", rd, {8'h0, (24'h12_3456 & 24'h00FF00) | (24'hA5_C3A5 & ~24'h00FF00)});
        bus_write(A_DIR, 32'hFFFF_FFFF);

        // R11 upper bits
        bus_read(A_DIR, rd); check("R11 direction upper", rd, 32'h00FF_FFFF);
        bus_write(A_IEN, 32'hFFFF_FFFF);
        bus_read(A_IEN, rd); check("R11 enable upper", rd, 32'h00FF_FFFF);
        bus_write(A_IEN, 32'h0);

        // R4 level triggers: pin0 active high, pin1 active low
        pin_in = '0; settle();
        bus_write(A_EDGE, 32'h0); bus_write(A_POL, 32'h1); bus_write(A_BOTH, 32'h0);
        bus_write(A_CLR, {8'h0, ALL});
        pin_in[0] = 1'b1; settle();
        bus_read(A_STAT, rd); check("R4 high level latched", rd & 32'h3, 32'h3);
        bus_write(A_CLR, 32'h1);
        bus_read(A_STAT, rd); check("R4 clear wins one cycle", rd & 32'h1, 32'h0);
        bus_read(A_STAT, rd); check("R4 level sets again", rd & 32'h1, 32'h1);

        // R5 single edges: pin2 rising, pin3 falling
        pin_in = '0; settle();
        bus_write(A_EDGE, {8'h0, ALL}); bus_write(A_POL, 32'h4); bus_write(A_BOTH, 32'h0);
        bus_write(A_CLR, {8'h0, ALL});
        pin_in[3:2] = 2'b11; settle();
        bus_read(A_STAT, rd); check("R5 rising only", rd & 32'hC, 32'h4);
        bus_write(A_CLR, {8'h0, ALL});
        pin_in[3:2] = 2'b00; settle();
        bus_read(A_STAT, rd); check("R5 falling only", rd & 32'hC, 32'h8);

        // R6 either edge on pin4; pin5 level-high with either-edge bit set
        bus_write(A_EDGE, 32'h10); bus_write(A_POL, 32'h20); bus_write(A_BOTH, 32'h30);
        bus_write(A_CLR, {8'h0, ALL});
        pin_in[4] = 1'b1; settle();
        bus_read(A_STAT, rd); check("R6 either edge up, both ignored on level", rd & 32'h30, 32'h10);
        bus_write(A_CLR, 32'h10);
        pin_in[4] = 1'b0; settle();
        bus_read(A_STAT, rd); check("R6 either edge down", rd & 32'h30, 32'h10);

        // R7 zero bits untouched; edge coinciding with clear kept (pin2 rising)
        bus_write(A_EDGE, {8'h0, ALL}); bus_write(A_POL, 32'h4); bus_write(A_BOTH, 32'h10);
        bus_write(A_CLR, {8'h0, ALL});
        pin_in[4] = 1'b1; settle();
        bus_write(A_CLR, 32'h4);
        bus_read(A_STAT, rd); check("R7 zero bits no effect", rd & 32'h10, 32'h10);
        pin_in[2] = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_write(A_CLR, 32'h4);
        bus_read(A_STAT, rd); check("R7 edge kept during clear", rd & 32'h4, 32'h4);

        // R8 writes to status and pending ignored
        bus_read(A_STAT, rd);
        bus_write(A_STAT, 32'h0); bus_write(A_PEND, 32'hFFFF_FFFF);
        bus_read(A_STAT, rd2); check("R8 status write ignored", rd2, rd);
        bus_read(A_PEND, rd2); check("R8 pending write ignored", rd2, 32'h0);

        // R9 several pins at once
        pin_in = '0; settle();
        bus_write(A_POL, {8'h0, ALL}); bus_write(A_BOTH, 32'h0);
        bus_write(A_IEN, 32'hF0);
        bus_write(A_CLR, {8'h0, ALL});
        pin_in[7:4] = 4'hF; settle();
        bus_read(A_IEN, rd); check("R9 enable kept", rd, 32'hF0);
        bus_read(A_PEND, rd); check("R9 pending", rd, 32'hF0);
        #1 check("R9 irq", {31'h0, irq}, 32'h1);
        bus_write(A_CLR, {8'h0, ALL});
        #1 check("R8 irq drops after clear", {31'h0, irq}, 32'h0);

        // Random trigger configurations against the model
        old_p = pin_in;
        for (int it = 0; it < 60; it++) begin
            e = NP'($urandom); p = NP'($urandom); b = NP'($urandom); en = NP'($urandom);
            bus_write(A_EDGE, {8'h0, e}); bus_write(A_POL, {8'h0, p});
            bus_write(A_BOTH, {8'h0, b}); bus_write(A_IEN, {8'h0, en});
            bus_write(A_CLR, {8'h0, ALL});
            @(negedge clk);
            if (it % 4 == 0)      new_p = old_p;
            else if (it % 4 == 1) new_p = old_p ^ (NP'(1) << ($urandom % NP));
            else                  new_p = NP'($urandom);
            pin_in = new_p; settle();
            exp_s = trig_expect(old_p, new_p, e, p, b);
            bus_read(A_STAT, rd); check("R4 R5 R6 random status", rd, {8'h0, exp_s});
            bus_read(A_PEND, rd); check("R8 random pending", rd, {8'h0, exp_s & en});
            #1 check("R8 random irq", {31'h0, irq}, {31'h0, |(exp_s & en)});
            old_p = new_p;
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule